// File: doc/BRIEF.md
# Frequency-Locked Speed Comparator

This block measures the rotation rate of a sensorless three-phase motor against a programmed target and reports the result as two pulse streams. A once-per-revolution tach level is built either by dividing the commutation zero-crossing toggle by the number of crossings in one revolution, or by taking an external sector signal directly. Every rising edge of tach launches a reference interval whose length is a programmed number of oscillator periods. The falling edge of tach is then raced against the falling edge of that interval. A motor that turns too fast loses the race and raises a fast-error pulse. A motor that turns too slowly raises a slow-error pulse. Either pulse lasts until the later of the two edges arrives.

The error pulses are meant to drive a charge pump and loop filter outside this block. A startup flag stays high from reset until the first fast-error event. That event shows the motor has passed the target speed, so downstream current control can leave its startup clamp. A sync output shows when the reference interval is running. Software changes the tach source only while sync is low. The target speed is rpm = 60 × f_osc / (8 × count), where count is the bitwise inverse of the 14-bit speed word.

Top module: `speed_lock_cmp`

## Requirements
- R1: With sector_mode low, tach toggles on the zero-crossing event that completes 3 × poles events since its last toggle. An event is any change of level on zc_toggle. The poles count is selected by pole_sel: 00 gives 4, 01 gives 8, 10 gives 12 and 11 gives 16. tach changes at the same clock edge that first samples the completing event.
- R2: With sector_mode high, tach equals sector_in as it was sampled at the previous clock edge.
- R3: When tach rises (its level differs from the previous cycle and is now high), ref_pulse goes high at the next clock. A rise that arrives while ref_pulse is already high reloads the interval and restarts it from the full length.
- R4: The interval ends after 8 × L cycles in which osc_en is high, where L is the bitwise inverse of speed_cnt_n. An osc_en pulse in the same cycle as a tach rise is not counted. If L is zero, a tach rise forces ref_pulse low.
- R5: A tach fall while ref_pulse is high makes err_fast high from the next clock until the clock after ref_pulse falls. A ref_pulse fall while tach stays high makes err_slow high from the next clock until the clock after tach falls. err_fast and err_slow are never high together.
- R6: If tach and ref_pulse fall in the same cycle, neither err_fast nor err_slow rises.
- R7: startup_boost is high out of reset. It goes low at the clock where err_fast first rises and stays low until the next reset.
- R8: sync is high exactly while ref_pulse is high.
- R9: While rst_n is low, tach (internal mode), ref_pulse, sync, err_fast and err_slow are low and startup_boost is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_toggle | input | 1 | Level that changes at every back-EMF zero crossing |
| sector_in | input | 1 | External once-around or sector tach level |
| osc_en | input | 1 | One-cycle tick per reference oscillator period |
| speed_cnt_n | input | 14 | Active-low programmed interval count, in units of 8 ticks |
| pole_sel | input | 2 | Pole count code: 00=4, 01=8, 10=12, 11=16 |
| sector_mode | input | 1 | High selects sector_in as the tach source |
| tach | output | 1 | Once-per-revolution tach level |
| ref_pulse | output | 1 | Reference interval, started by each tach rise |
| err_fast | output | 1 | Motor-too-fast error pulse |
| err_slow | output | 1 | Motor-too-slow error pulse |
| sync | output | 1 | Reference interval is running |
| startup_boost | output | 1 | Startup flag, cleared by the first fast error |

## Verification
Two clashes are targeted. The first is a tach fall and the end of the reference interval landing in the same cycle. In sector mode with one tick per cycle and L = 1, the sector level is held high for exactly nine cycles, and no error pulse may appear. Holding it for eight or ten cycles must give a single fast or slow pulse instead. The second clash is a tach rise in the same cycle as an oscillator tick, which the random phase provokes often. A cycle-level bench model, which counts remaining ticks rather than prescaler steps, judges every output on every cycle. A directed retrigger case checks that the restarted interval lasts 6 + 8 × L cycles.

// File: rtl/spdcmp_pkg.sv
package spdcmp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FAST = 2'd1,
    PH_SLOW = 2'd2
  } phase_e;

  // zero-crossing events per revolution: 3 per pole, poles = 4*(code+1)
  function automatic int unsigned rev_events(input int unsigned code);
    return 12 * (code + 1);
  endfunction

endpackage

// File: rtl/spdcmp_tach.sv
module spdcmp_tach #(
  parameter int POLE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_toggle,
  input  logic              sector_in,
  input  logic              sector_mode,
  input  logic [POLE_W-1:0] pole_sel,
  output logic              tach,
  output logic              tach_rise,
  output logic              tach_fall
);
  import spdcmp_pkg::*;

  localparam int MAX_EVT = 12 * (2 ** POLE_W);
  localparam int EVT_W   = $clog2(MAX_EVT);

  logic             zc_q;
  logic             zc_evt;
  logic [EVT_W-1:0] evt_cnt;
  logic [EVT_W-1:0] evt_lim;
  logic             tach_int;
  logic             sec_q;
  logic             tach_prev;

  assign zc_evt  = zc_toggle ^ zc_q;
  assign evt_lim = EVT_W'(rev_events(int'(pole_sel)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q     <= 1'b0;
      evt_cnt  <= '0;
      tach_int <= 1'b0;
    end else begin
      zc_q <= zc_toggle;
      if (zc_evt) begin
        if (evt_cnt >= evt_lim) begin
          evt_cnt  <= '0;
          tach_int <= ~tach_int;
        end else begin
          evt_cnt <= evt_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= 1'b0;
      tach_prev <= 1'b0;
    end else begin
      sec_q     <= sector_in;
      tach_prev <= tach;
    end
  end

  assign tach      = sector_mode ? sec_q : tach_int;
  assign tach_rise = tach & ~tach_prev;
  assign tach_fall = ~tach & tach_prev;

  // R1: the internal tach only moves when a zero-crossing event was seen
  p_tach_on_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_int != $past(tach_int)) |-> $past(zc_evt));

  // R1: the event counter never passes the per-revolution limit of 16 poles
  p_evt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cnt < EVT_W'(MAX_EVT));

endmodule

// File: rtl/spdcmp_ref.sv
module spdcmp_ref #(
  parameter int CNT_W = 14,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_rise,
  input  logic             osc_en,
  input  logic [CNT_W-1:0] speed_cnt_n,
  output logic             ref_on,
  output logic             ref_fall
);

  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic             pre_last;
  logic             ref_prev;

  assign load     = ~speed_cnt_n;
  assign pre_last = &pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pre    <= '0;
      ref_on <= 1'b0;
    end else if (tach_rise) begin
      cnt    <= load;
      pre    <= '0;
      ref_on <= (load != '0);
    end else if (ref_on && osc_en) begin
      pre <= pre + 1'b1;
      if (pre_last) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) ref_on <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev <= 1'b0;
    else        ref_prev <= ref_on;
  end

  assign ref_fall = ref_prev & ~ref_on;

  // R3: the interval only starts after a tach rise
  p_ref_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_on) |-> $past(tach_rise));

  // R3: a rise with a nonzero count always (re)starts the interval
  p_ref_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_rise && load != '0) |=> ref_on);

  // R4: a zero count disables the interval
  p_ref_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tach_rise && load == '0) |=> !ref_on);

  // R4: without a tick the interval cannot end
  p_ref_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_on && !osc_en && !tach_rise) |=> ref_on);

endmodule

// File: rtl/spdcmp_phase.sv
module spdcmp_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_fall,
  input  logic ref_fall,
  input  logic ref_on,
  output logic err_fast,
  output logic err_slow,
  output logic startup_boost
);
  import spdcmp_pkg::*;

  phase_e state;
  phase_e state_nx;
  logic   enter_fast;

  assign enter_fast = (state == PH_IDLE) && tach_fall && ref_on;

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE: begin
        if (enter_fast)                  state_nx = PH_FAST;
        else if (ref_fall && !tach_fall) state_nx = PH_SLOW;
      end
      PH_FAST: if (ref_fall)  state_nx = PH_IDLE;
      PH_SLOW: if (tach_fall) state_nx = PH_IDLE;
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= PH_IDLE;
      startup_boost <= 1'b1;
    end else begin
      state <= state_nx;
      if (enter_fast) startup_boost <= 1'b0;
    end
  end

  assign err_fast = (state == PH_FAST);
  assign err_slow = (state == PH_SLOW);

  // R5: the two error pulses exclude each other
  p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_fast && err_slow));

  // R5: a fast pulse starts only after tach fell during the interval
  p_fast_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_fast) |-> $past(tach_fall && ref_on));

  // R5: a slow pulse starts only after the interval ended alone
  p_slow_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_slow) |-> $past(ref_fall && !tach_fall));

  // R6: coincident falls from idle leave both errors low
  p_tie_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && tach_fall && ref_fall) |=> (!err_fast && !err_slow));

  // R7: the startup flag never comes back before reset
  p_boost_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_boost |=> !startup_boost);

  // R7: the flag is already low when a fast pulse begins
  p_boost_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_fast) |-> !startup_boost);

endmodule

// File: rtl/speed_lock_cmp.sv
module speed_lock_cmp #(
  parameter int CNT_W  = 14,
  parameter int POLE_W = 2,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_toggle,
  input  logic              sector_in,
  input  logic              osc_en,
  input  logic [CNT_W-1:0]  speed_cnt_n,
  input  logic [POLE_W-1:0] pole_sel,
  input  logic              sector_mode,
  output logic              tach,
  output logic              ref_pulse,
  output logic              err_fast,
  output logic              err_slow,
  output logic              sync,
  output logic              startup_boost
);

  logic tach_rise;
  logic tach_fall;
  logic ref_on;
  logic ref_fall;

  spdcmp_tach #(.POLE_W(POLE_W)) u_tach (
    .clk         (clk),
    .rst_n       (rst_n),
    .zc_toggle   (zc_toggle),
    .sector_in   (sector_in),
    .sector_mode (sector_mode),
    .pole_sel    (pole_sel),
    .tach        (tach),
    .tach_rise   (tach_rise),
    .tach_fall   (tach_fall)
  );

  spdcmp_ref #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ref (
    .clk         (clk),
    .rst_n       (rst_n),
    .tach_rise   (tach_rise),
    .osc_en      (osc_en),
    .speed_cnt_n (speed_cnt_n),
    .ref_on      (ref_on),
    .ref_fall    (ref_fall)
  );

  spdcmp_phase u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .tach_fall     (tach_fall),
    .ref_fall      (ref_fall),
    .ref_on        (ref_on),
    .err_fast      (err_fast),
    .err_slow      (err_slow),
    .startup_boost (startup_boost)
  );

  assign ref_pulse = ref_on;
  assign sync      = ref_on;

  // R8: sync and the reference pulse move together
  p_sync_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(tach_rise));

endmodule

// File: tb/test_speed_lock_cmp.sv
`timescale 1ns/1ps
module test_speed_lock_cmp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        zc = 1'b0, sec = 1'b0, osc = 1'b0, smode = 1'b0;
  logic [13:0] scn = 14'h3FFF;
  logic [1:0]  ps = 2'd0;
  logic tach, ref_pulse, err_fast, err_slow, sync, boost;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  logic m_zc, m_ti, m_sec, m_tp, m_ref, m_rp, m_yank;
  int   m_zn, m_left, m_ph;
  bit   seen_fast, seen_slow, seen_ref;
  int   ref_hi_cnt;

  always #2 clk = ~clk;

  speed_lock_cmp i_speed_lock_cmp (
    .clk(clk), .rst_n(rst_n), .zc_toggle(zc), .sector_in(sec), .osc_en(osc),
    .speed_cnt_n(scn), .pole_sel(ps), .sector_mode(smode),
    .tach(tach), .ref_pulse(ref_pulse), .err_fast(err_fast), .err_slow(err_slow),
    .sync(sync), .startup_boost(boost)
  );

  function automatic int exp_events(input int code);
    return 3 * (4 + 4 * code);
  endfunction

  function automatic int exp_ticks(input int l);
    return l << 3;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_zc = 0; m_ti = 0; m_sec = 0; m_tp = 0; m_ref = 0; m_rp = 0; m_yank = 1;
    m_zn = 0; m_left = 0; m_ph = 0;
  endtask

  // one clock: advance the model with the applied inputs, then compare
  task automatic cyc();
    logic t_now, rise, fall, rf;
    int   load;
    load  = int'(14'(~scn));
    t_now = smode ? m_sec : m_ti;
    rise  = t_now && !m_tp;
    fall  = !t_now && m_tp;
    rf    = m_rp && !m_ref;
    case (m_ph)
      0: if (fall && m_ref) begin m_ph = 1; m_yank = 0; end
         else if (rf && !fall) m_ph = 2;
      1: if (rf) m_ph = 0;
      default: if (fall) m_ph = 0;
    endcase
    m_rp = m_ref;
    if (rise) begin
      m_left = exp_ticks(load);
      m_ref  = (load != 0);
    end else if (m_ref && osc) begin
      m_left--;
      if (m_left == 0) m_ref = 0;
    end
    m_tp = t_now;
    if (zc != m_zc) begin
      m_zn++;
      if (m_zn >= exp_events(int'(ps))) begin m_zn = 0; m_ti = !m_ti; end
    end
    m_zc  = zc;
    m_sec = sec;
    @(posedge clk);
    #1;
    chk(tach, smode ? m_sec : m_ti, smode ? "R2 tach" : "R1 tach");
    chk(ref_pulse, m_ref, "R3,R4 ref_pulse");
    chk(sync, m_ref, "R8 sync");
    chk(err_fast, m_ph == 1, "R5 err_fast");
    chk(err_slow, m_ph == 2, "R5 err_slow");
    chk(boost, m_yank, "R7 startup_boost");
    if (err_fast) seen_fast = 1;
    if (err_slow) seen_slow = 1;
    if (ref_pulse) begin seen_ref = 1; ref_hi_cnt++; end
  endtask

  task automatic quiet(input logic [13:0] cnt_n);
    smode = 1; sec = 0; osc = 1; scn = cnt_n;
    repeat (80) cyc();
    seen_fast = 0; seen_slow = 0; seen_ref = 0; ref_hi_cnt = 0;
  endtask

  task automatic sector_pulse(input int h);
    sec = 1;
    repeat (h) cyc();
    sec = 0;
    repeat (30) cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    // R9: reset values
    chk(tach, 1'b0, "R9 tach");
    chk(ref_pulse, 1'b0, "R9 ref_pulse");
    chk(sync, 1'b0, "R9 sync");
    chk(err_fast, 1'b0, "R9 err_fast");
    chk(err_slow, 1'b0, "R9 err_slow");
    chk(boost, 1'b1, "R9 startup_boost");
    model_reset();
    rst_n = 1;

    // R1: code 10 means 12 poles, 36 events per toggle
    ps = 2'd2; smode = 0; scn = ~14'd1;
    for (int i = 0; i < 35; i++) begin zc = ~zc; cyc(); end
    chk(tach, 1'b0, "R1 before 36th event");
    zc = ~zc; cyc();
    chk(tach, 1'b1, "R1 at 36th event");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        ps    = 2'($urandom_range(0, 3));
        smode = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 7) == 0) scn = 14'h3FFF;
        else scn = ~14'($urandom_range(1, 6));
      end
      if ($urandom_range(0, 1) == 1) zc = ~zc;
      osc = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 29) == 0) sec = ~sec;
      cyc();
    end

    // R6: both falls in one cycle
    quiet(~14'd1);
    sector_pulse(9);
    chk(seen_fast | seen_slow, 1'b0, "R6 tie gives no error");

    // R5 and R7: tach falls one cycle early
    quiet(~14'd1);
    sector_pulse(8);
    chk(seen_fast, 1'b1, "R5 fast pulse seen");
    chk(seen_slow, 1'b0, "R5 no slow pulse");
    chk(boost, 1'b0, "R7 flag cleared after fast");

    // R5: tach falls one cycle late
    quiet(~14'd1);
    sector_pulse(10);
    chk(seen_slow, 1'b1, "R5 slow pulse seen");
    chk(seen_fast, 1'b0, "R5 no fast pulse");
    chk(boost, 1'b0, "R7 flag stays low");

    // R4: zero count keeps the interval off
    quiet(14'h3FFF);
    sector_pulse(9);
    chk(seen_ref, 1'b0, "R4 zero count disables");

    // R4: interval length with one tick per cycle
    quiet(~14'd3);
    sector_pulse(40);
    chk_int(ref_hi_cnt, exp_ticks(3), "R4 interval length");

    // R3: retrigger while running
    quiet(~14'd2);
    sec = 1; repeat (3) cyc();
    sec = 0; repeat (3) cyc();
    sec = 1; repeat (30) cyc();
    sec = 0; repeat (5) cyc();
    chk_int(ref_hi_cnt, 6 + exp_ticks(2), "R3 retrigger reload");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule